// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block turns CPU write and erase requests into timed operations on a word-organised flash array that is modelled in RTL. The array is split into sixteen equal sections. Each section holds one or more pages. A page holds 256 words when the block is built in its data-store configuration, or 512 words in its code-store configuration.

Programming follows flash rules: it can only clear bits, so the new content is the old word ANDed with the written word. Only an erase sets bits back to one, and it does so for a whole page. Requests are checked at acceptance against two things:

- a 16-bit section write-enable mask held inside the block;
- a boot-area limit, given as a count of sections starting at address 0.

A request that fails the check is dropped, and a sticky error flag records it.

The block keeps one request waiting behind the running one. BUSY covers the running operation. FULL reports that the waiting slot is taken. The operation length is a cycle count set by a parameter. CPU reads of the array are refused while an operation runs. Software is expected to erase a page before it programs it, because the array starts with undefined content.

Top module: `flash_seq`

## Requirements
- R1: After reset, busy, full, err and rd_valid are 0, and the write-enable mask is all zero, so a program request is refused (busy stays 0 and err rises).
- R2: An accepted program request raises busy on the next clock edge and keeps it high for exactly PROG_CYCLES cycles. Afterwards the addressed word equals its old value ANDed with req_data, so no bit can change from 0 to 1.
- R3: An accepted erase (req_erase=1) sets every word of the page that holds req_addr to all ones. With the default parameters a page is 256 words, so words 0x100 to 0x1FF form page 1. Words outside that page keep their values. Busy is high for exactly ERASE_CYCLES cycles.
- R4: The section of a request is req_addr[11:8] with the default parameters. Bit i of the write-enable mask (loaded with wen_we/wen_din) permits section i, and bit 0 is the lowest-address section. A request to a disabled section leaves the array unchanged and sets err.
- R5: An erase of a page whose section index is below boot_sects is refused and sets err. A program request in that area is still carried out when its section is enabled.
- R6: A request accepted while an operation runs is held pending, and full is 1 from the next edge. The pending request starts as the running one ends, without a gap in busy, and full then clears. A request arriving while full is 1 is ignored and sets err.
- R7: err is sticky. It is cleared by err_clr=1. If a new error and err_clr occur in the same cycle, err stays 1.
- R8: A read with rd_en=1 while busy=0 returns rd_valid=1 and the word in rd_data one cycle later. A read issued while busy=1 is not serviced, and rd_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wen_we | input | 1 | Load the section write-enable mask |
| wen_din | input | SECTS | New write-enable mask, bit i for section i |
| boot_sects | input | SW+1 | Boot area size in sections from address 0 |
| req_valid | input | 1 | Request strobe |
| req_erase | input | 1 | 1 = page erase, 0 = word program |
| req_addr | input | AW | Word address of the request |
| req_data | input | WORD_W | Program data |
| err_clr | input | 1 | Write-one-to-clear for err |
| rd_en | input | 1 | Array read strobe |
| rd_addr | input | AW | Array read word address |
| rd_data | output | WORD_W | Read data |
| rd_valid | output | 1 | rd_data holds a serviced read |
| busy | output | 1 | Operation in progress |
| full | output | 1 | Pending slot occupied |
| err | output | 1 | Sticky request error |

## Verification
Each result has its own latency:

- busy, full and err change on the first clock edge after the request is sampled.
- rd_valid and rd_data appear one edge after rd_en.
- busy then stays high for exactly PROG_CYCLES or ERASE_CYCLES edges, or for both lengths back to back when a request is pending.

The bench drives inputs and samples outputs on falling edges. It counts the falling edges during which busy is high and compares that count with the exact duration. It reads the array only after busy has dropped, and checks flags on the falling edge right after the edge that updates them.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_PROG  = 2'd1,
    ENG_ERASE = 2'd2
  } eng_st_t;
endpackage

// File: rtl/flash_seq_array.sv
// Word array: one synchronous read port and one write port (block RAM shape).
module flash_seq_array #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 4096,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/flash_seq_gate.sv
// Permission check for a request: section enable, plus boot-area guard for erase.
module flash_seq_gate #(
  parameter int SECTS = 16,
  parameter int SW    = 4,
  parameter int BW    = 5
) (
  input  logic [SW-1:0]    sect,
  input  logic             erase,
  input  logic [SECTS-1:0] wen_mask,
  input  logic [BW-1:0]    boot_sects,
  output logic             ok
);
  logic in_boot;

  always_comb begin
    in_boot = ({1'b0, sect} < boot_sects);
    ok      = wen_mask[sect] && !(erase && in_boot);
  end
endmodule

// File: rtl/flash_seq_engine.sv
// Runs one program or erase at a time and drives the array ports.
module flash_seq_engine
  import flash_seq_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int AW         = 12,
  parameter int PW         = 8,
  parameter int PAGE_WORDS = 256,
  parameter int PROG_T     = 4,
  parameter int ERASE_T    = 260,
  parameter int CW         = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_erase,
  input  logic [AW-1:0]     start_addr,
  input  logic [WORD_W-1:0] start_data,
  output logic              busy,
  output logic              avail,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data
);
  eng_st_t           st;
  logic [CW-1:0]     cnt;
  logic [AW-1:0]     a_q;
  logic [WORD_W-1:0] d_q;
  logic              last;

  always_comb begin
    last = ((st == ENG_PROG)  && (cnt == CW'(PROG_T - 1))) ||
           ((st == ENG_ERASE) && (cnt == CW'(ERASE_T - 1)));
    busy  = (st != ENG_IDLE);
    avail = (st == ENG_IDLE) || last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ENG_IDLE;
      cnt <= '0;
    end else if (start && avail) begin
      st  <= start_erase ? ENG_ERASE : ENG_PROG;
      cnt <= '0;
    end else if (last) begin
      st  <= ENG_IDLE;
      cnt <= '0;
    end else if (st != ENG_IDLE) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (start && avail) begin
      a_q <= start_addr;
      d_q <= start_data;
    end
  end

  // Program: fetch the old word in the first cycle, merge and write in the last.
  // Erase: sweep one word per cycle across the page.
  always_comb begin
    mem_rd_en   = (st == ENG_PROG) && (cnt == '0);
    mem_rd_addr = a_q;
    if (st == ENG_ERASE) begin
      mem_wr_en   = (cnt < CW'(PAGE_WORDS));
      mem_wr_addr = {a_q[AW-1:PW], cnt[PW-1:0]};
      mem_wr_data = '1;
    end else begin
      mem_wr_en   = (st == ENG_PROG) && last;
      mem_wr_addr = a_q;
      mem_wr_data = mem_rd_data & d_q;
    end
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int WORD_W         = 16,
  parameter int SECTS          = 16,
  parameter int PAGES_PER_SECT = 1,
  parameter int DATA_CFG       = 1,
  parameter int PROG_CYCLES    = 4,
  parameter int ERASE_CYCLES   = 260,
  localparam int PAGE_WORDS    = (DATA_CFG != 0) ? 256 : 512,
  localparam int PW            = $clog2(PAGE_WORDS),
  localparam int DEPTH         = SECTS * PAGES_PER_SECT * PAGE_WORDS,
  localparam int AW            = $clog2(DEPTH),
  localparam int SW            = $clog2(SECTS),
  localparam int BW            = SW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wen_we,
  input  logic [SECTS-1:0]  wen_din,
  input  logic [BW-1:0]     boot_sects,
  input  logic              req_valid,
  input  logic              req_erase,
  input  logic [AW-1:0]     req_addr,
  input  logic [WORD_W-1:0] req_data,
  input  logic              err_clr,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              full,
  output logic              err
);
  localparam int PROG_T  = (PROG_CYCLES < 2) ? 2 : PROG_CYCLES;
  localparam int ERASE_T = (ERASE_CYCLES < PAGE_WORDS) ? PAGE_WORDS : ERASE_CYCLES;
  localparam int CW      = $clog2(((ERASE_T > PROG_T) ? ERASE_T : PROG_T) + 1);

  logic [SECTS-1:0]  wen_q;
  logic              pend_v, pend_erase;
  logic [AW-1:0]     pend_addr;
  logic [WORD_W-1:0] pend_data;
  logic              err_q, rdv_q;
  logic              req_ok, acc_ok;
  logic              eng_busy, eng_avail, eng_start;
  logic              st_erase;
  logic [AW-1:0]     st_addr;
  logic [WORD_W-1:0] st_data;
  logic              e_rd_en, e_wr_en;
  logic [AW-1:0]     e_rd_addr, e_wr_addr;
  logic [WORD_W-1:0] e_wr_data, m_rd_data;
  logic              m_rd_en, cpu_rd;
  logic [AW-1:0]     m_rd_addr;

  flash_seq_gate #(.SECTS(SECTS), .SW(SW), .BW(BW)) u_gate (
    .sect      (req_addr[AW-1 -: SW]),
    .erase     (req_erase),
    .wen_mask  (wen_q),
    .boot_sects(boot_sects),
    .ok        (req_ok)
  );

  // Pending slot has priority when the engine frees up.
  always_comb begin
    acc_ok    = req_valid && !pend_v && req_ok;
    eng_start = eng_avail && (pend_v || acc_ok);
    st_erase  = pend_v ? pend_erase : req_erase;
    st_addr   = pend_v ? pend_addr  : req_addr;
    st_data   = pend_v ? pend_data  : req_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q  <= '0;
      pend_v <= 1'b0;
      err_q  <= 1'b0;
      rdv_q  <= 1'b0;
    end else begin
      if (wen_we) wen_q <= wen_din;
      if (pend_v && eng_avail)      pend_v <= 1'b0;
      else if (acc_ok && !eng_avail) pend_v <= 1'b1;
      if (req_valid && (pend_v || !req_ok)) err_q <= 1'b1;
      else if (err_clr)                     err_q <= 1'b0;
      rdv_q <= cpu_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_ok && !eng_avail) begin
      pend_erase <= req_erase;
      pend_addr  <= req_addr;
      pend_data  <= req_data;
    end
  end

  flash_seq_engine #(
    .WORD_W(WORD_W), .AW(AW), .PW(PW), .PAGE_WORDS(PAGE_WORDS),
    .PROG_T(PROG_T), .ERASE_T(ERASE_T), .CW(CW)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start      (eng_start),
    .start_erase(st_erase),
    .start_addr (st_addr),
    .start_data (st_data),
    .busy       (eng_busy),
    .avail      (eng_avail),
    .mem_rd_en  (e_rd_en),
    .mem_rd_addr(e_rd_addr),
    .mem_rd_data(m_rd_data),
    .mem_wr_en  (e_wr_en),
    .mem_wr_addr(e_wr_addr),
    .mem_wr_data(e_wr_data)
  );

  // CPU reads use the array port only while the engine is idle.
  always_comb begin
    cpu_rd    = rd_en && !eng_busy;
    m_rd_en   = e_rd_en || cpu_rd;
    m_rd_addr = eng_busy ? e_rd_addr : rd_addr;
  end

  flash_seq_array #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk    (clk),
    .rd_en  (m_rd_en),
    .rd_addr(m_rd_addr),
    .rd_data(m_rd_data),
    .wr_en  (e_wr_en),
    .wr_addr(e_wr_addr),
    .wr_data(e_wr_data)
  );

  assign rd_data  = m_rd_data;
  assign rd_valid = rdv_q;
  assign busy     = eng_busy;
  assign full     = pend_v;
  assign err      = err_q;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic full,
  input logic busy,
  input logic err,
  input logic err_clr,
  input logic rd_en,
  input logic rd_valid,
  input logic gate_ok
);
  assert_full_implies_busy_R6: assert property (@(posedge clk) disable iff (rst)
    full |-> busy);
  assert_ignore_when_full_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid && full |=> err);
  assert_start_on_accept_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid && !full && gate_ok |=> busy);
  assert_reject_sets_err_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid && !gate_ok |=> err);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err && !err_clr |=> err);
  assert_err_clear_R7: assert property (@(posedge clk) disable iff (rst)
    err_clr && !req_valid |=> !err);
  assert_no_read_busy_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en && busy |=> !rd_valid);
  assert_read_served_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en && !busy |=> rd_valid);
endmodule

bind flash_seq flash_seq_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .full(full), .busy(busy),
  .err(err), .err_clr(err_clr), .rd_en(rd_en), .rd_valid(rd_valid),
  .gate_ok(req_ok)
);

// File: tb/sim_flash_seq.sv
module sim_flash_seq;
  localparam int CLK_NS = 10;
  localparam int PROG   = 4;
  localparam int ERASE  = 260;

  logic        clk = 1'b0;
  logic        rst;
  logic        wen_we;
  logic [15:0] wen_din;
  logic [4:0]  boot_sects;
  logic        req_valid, req_erase;
  logic [11:0] req_addr;
  logic [15:0] req_data;
  logic        err_clr, rd_en;
  logic [11:0] rd_addr;
  logic [15:0] rd_data;
  logic        rd_valid, busy, full, err;

  always #(CLK_NS/2) clk = ~clk;

  flash_seq u0 (
    .clk(clk), .rst(rst), .wen_we(wen_we), .wen_din(wen_din),
    .boot_sects(boot_sects), .req_valid(req_valid), .req_erase(req_erase),
    .req_addr(req_addr), .req_data(req_data), .err_clr(err_clr),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .full(full), .err(err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // {addr, program data, expected word afterwards}
  localparam logic [43:0] VEC [9] = '{
    {12'h105, 16'hF0F0, 16'hF0F0},
    {12'h105, 16'h3CFF, 16'h30F0},
    {12'h105, 16'hFFFF, 16'h30F0},
    {12'h2FF, 16'h1234, 16'h1234},
    {12'hF00, 16'hA5A5, 16'hA5A5},
    {12'h000, 16'h0001, 16'h0001},
    {12'h0FF, 16'h1111, 16'h1111},
    {12'h200, 16'h2222, 16'h2222},
    {12'h1FF, 16'h0000, 16'h0000}
  };

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic send(logic er, logic [11:0] a, logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_erase = er; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [15:0] d, output logic v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_valid; d = rd_data;
  endtask

  task automatic set_mask(logic [15:0] m);
    @(negedge clk);
    wen_we = 1'b1; wen_din = m;
    @(negedge clk);
    wen_we = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic expect_word(string rq, logic [11:0] a, logic [15:0] exp);
    logic [15:0] d;
    logic v;
    rd(a, d, v);
    chk(rq, {31'd0, v}, 32'd1);
    chk(rq, {16'd0, d}, {16'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] d;
    logic v;
    rst = 1'b1; wen_we = 1'b0; wen_din = '0; boot_sects = '0;
    req_valid = 1'b0; req_erase = 1'b0; req_addr = '0; req_data = '0;
    err_clr = 1'b0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 full", {31'd0, full}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    send(1'b0, 12'h010, 16'h0000);
    chk("R1 mask zero refuses", {31'd0, busy}, 32'd0);
    chk("R1 refuse sets err", {31'd0, err}, 32'd1);
    clear_err();
    chk("R7 clear", {31'd0, err}, 32'd0);

    // Prepare: enable all, erase every page
    set_mask(16'hFFFF);
    for (int s = 0; s < 16; s++) begin
      send(1'b1, 12'(s << 8), 16'h0);
      wait_idle(n);
      if (s == 0) chk("R3 erase duration", n, ERASE);
    end

    // R2: vector walk
    for (int i = 0; i < 9; i++) begin
      send(1'b0, VEC[i][43:32], VEC[i][31:16]);
      wait_idle(n);
      chk("R2 program duration", n, PROG);
      expect_word("R2 AND merge", VEC[i][43:32], VEC[i][15:0]);
    end

    // R3: erase page 1, neighbours untouched
    send(1'b1, 12'h105, 16'h0);
    wait_idle(n);
    chk("R3 erase duration", n, ERASE);
    expect_word("R3 page first", 12'h100, 16'hFFFF);
    expect_word("R3 page word", 12'h105, 16'hFFFF);
    expect_word("R3 page last", 12'h1FF, 16'hFFFF);
    expect_word("R3 below page", 12'h0FF, 16'h1111);
    expect_word("R3 above page", 12'h200, 16'h2222);

    // R4: disabled section 15
    set_mask(16'h7FFF);
    send(1'b0, 12'hF00, 16'h0000);
    chk("R4 no start", {31'd0, busy}, 32'd0);
    chk("R4 err", {31'd0, err}, 32'd1);
    expect_word("R4 untouched", 12'hF00, 16'hA5A5);
    clear_err();

    // R5: boot area of three sections
    boot_sects = 5'd3;
    send(1'b1, 12'h2FF, 16'h0);
    chk("R5 boot erase refused", {31'd0, busy}, 32'd0);
    chk("R5 err", {31'd0, err}, 32'd1);
    expect_word("R5 boot kept", 12'h2FF, 16'h1234);
    clear_err();
    send(1'b0, 12'h000, 16'h0000);
    chk("R5 boot program runs", {31'd0, busy}, 32'd1);
    wait_idle(n);
    expect_word("R5 boot program", 12'h000, 16'h0000);
    send(1'b1, 12'h300, 16'h0);
    chk("R5 erase above boot", {31'd0, busy}, 32'd1);
    wait_idle(n);
    chk("R5 erase above boot duration", n, ERASE);

    // R6: pending slot and overflow
    send(1'b0, 12'h400, 16'h00FF);
    chk("R6 busy first", {31'd0, busy}, 32'd1);
    chk("R6 not full", {31'd0, full}, 32'd0);
    req_valid = 1'b1; req_erase = 1'b0; req_addr = 12'h401; req_data = 16'hFF00;
    @(negedge clk);
    chk("R6 full", {31'd0, full}, 32'd1);
    req_addr = 12'h402; req_data = 16'h0000;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 overflow err", {31'd0, err}, 32'd1);
    chk("R6 still full", {31'd0, full}, 32'd1);
    @(negedge clk);
    @(negedge clk);
    chk("R6 full clears on start", {31'd0, full}, 32'd0);
    wait_idle(n);
    chk("R6 busy no gap", n, 2 * PROG - 4);
    expect_word("R6 first", 12'h400, 16'h00FF);
    expect_word("R6 second", 12'h401, 16'hFF00);
    expect_word("R6 ignored", 12'h402, 16'hFFFF);

    // R7: set wins over clear
    @(negedge clk);
    req_valid = 1'b1; req_erase = 1'b0; req_addr = 12'hF10; err_clr = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; err_clr = 1'b0;
    chk("R7 set wins", {31'd0, err}, 32'd1);
    clear_err();
    chk("R7 cleared", {31'd0, err}, 32'd0);

    // R8: read during busy is not serviced
    send(1'b0, 12'h500, 16'h0F0F);
    rd(12'h500, d, v);
    chk("R8 no read while busy", {31'd0, v}, 32'd0);
    wait_idle(n);
    expect_word("R8 read after idle", 12'h500, 16'h0F0F);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule